// File: doc/BRIEF.md
# RV32I Integer ALU

This block is the integer execute unit of a small RISC-V core. It takes two 32-bit source values and a 4-bit operation code, and returns a 32-bit result in the same time step. It covers the register-register operations of the base integer set: add, subtract, the three bitwise logic operations, signed and unsigned set-less-than, and the three shifts.

The block holds no state and has no clock. The add/subtract unit, the comparator and the shifter all work in parallel, and the operation code picks one of their results. Each operation reads the same bit vector either as two's-complement or as unsigned, as that operation requires. The shifts use only the low five bits of the second operand. Add and subtract wrap silently and give no overflow indication.

Top module: `rv_int_alu`

## Requirements
- R1: With op code 4'b0000 (add), the result is the low 32 bits of src_a + src_b. For example, 0x7FFFFFFF + 1 gives 0x80000000, and there is no other output.
- R2: With op code 4'b1000 (subtract), the result is the low 32 bits of src_a - src_b. For example, 0 - 1 gives 0xFFFFFFFF.
- R3: Op code 4'b0100 gives the bitwise XOR, 4'b0110 gives the bitwise OR, and 4'b0111 gives the bitwise AND of the two sources.
- R4: With op code 4'b0010 (signed less-than), the result is 32'd1 when src_a < src_b as two's-complement values, and 32'd0 otherwise. For example, 0x80000000 against 0x7FFFFFFF gives 1.
- R5: With op code 4'b0011 (unsigned less-than), the result is 32'd1 when src_a < src_b as unsigned values, and 32'd0 otherwise. For example, 0x80000000 against 0x7FFFFFFF gives 0.
- R6: With op code 4'b0001, src_a is shifted left by src_b[4:0] and the vacated low bits are filled with zeros.
- R7: With op code 4'b0101, src_a is shifted right by src_b[4:0] and the vacated high bits are filled with zeros.
- R8: With op code 4'b1101, src_a is shifted right by src_b[4:0] and the vacated high bits are filled with copies of src_a[31]. For example, 0x80000000 shifted by 31 gives 0xFFFFFFFF.
- R9: For all three shifts, src_b[31:5] has no effect. A shift amount of 32 (0x20) acts as a shift of 0.
- R10: Every op code not listed above gives a result of zero.
- R11: The result depends only on the present inputs. It settles within the same time step as an input change, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (encoding in R1 to R10) |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand; bits [4:0] give the shift amount |
| result | output | 32 | Result of the selected operation |

## Verification
Directed vectors put 0, -1, INT_MIN and INT_MAX on both operands under every op code. These catch wrap errors in add and subtract and sign-fill errors in the right shifts. The pairs where the two sources have opposite sign bits separate the signed compare from the unsigned compare, because only on those pairs do the two answers differ. Shift amounts with bits set above bit 4, including exactly 32, show whether the upper operand bits reach the shifter. Seeded random pairs, together with random codes from the unused range, check the general case and the zero result for illegal codes.

// File: rtl/rv_alu_pkg.sv
// Package: operation codes shared by the ALU and its sub-units.
// Assumes a 4-bit code. Bit 3 chooses the alternate form (subtract, arithmetic shift).
package rv_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'b0000,
        OP_SLL  = 4'b0001,
        OP_SLT  = 4'b0010,
        OP_SLTU = 4'b0011,
        OP_XOR  = 4'b0100,
        OP_SRL  = 4'b0101,
        OP_OR   = 4'b0110,
        OP_AND  = 4'b0111,
        OP_SUB  = 4'b1000,
        OP_SRA  = 4'b1101
    } alu_op_e;

endpackage

// File: rtl/rv_alu_addsub.sv
// Adder/subtractor: one carry chain computes a + b, or a - b as a + ~b + 1.
// Assumes the result wraps modulo 2**W. There is no carry or overflow output.
module rv_alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum
);

    logic [W-1:0] b_eff;
    logic [W-1:0] cin_vec;

    // Invert b and inject a carry-in of one when subtracting.
    always_comb begin
        b_eff   = b ^ {W{sub}};
        cin_vec = {{(W-1){1'b0}}, sub};
    end

    // Single wrapping sum; bits above W-1 are discarded.
    assign sum = a + b_eff + cin_vec;

    // Inverse-operation checks: undoing the operation gives back a.
    always_comb begin
        if (!$isunknown({a, b, sub})) begin
            if (!sub)
                assert_add_wrap_R1: assert ((sum - b) == a)
                    else $error("add result does not invert");
            else
                assert_sub_wrap_R2: assert ((sum + b) == a)
                    else $error("sub result does not invert");
        end
    end

endmodule

// File: rtl/rv_alu_cmp.sv
// Comparator: produces the signed and the unsigned less-than of a and b.
// Assumes two's-complement values for the signed form. The signed form is
// taken from the unsigned one plus the two sign bits.
module rv_alu_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         lt_s,
    output logic         lt_u
);

    logic sign_diff;

    // Unsigned magnitude compare, and detection of opposite sign bits.
    always_comb begin
        lt_u      = (a < b);
        sign_diff = a[W-1] ^ b[W-1];
    end

    // With opposite signs, the negative operand is the smaller one.
    always_comb begin
        lt_s = sign_diff ? a[W-1] : lt_u;
    end

    // The two forms agree exactly when the sign bits match.
    always_comb begin
        if (!$isunknown({a, b})) begin
            if (a[W-1] == b[W-1])
                assert_cmp_agree_R4: assert (lt_s == lt_u)
                    else $error("signed/unsigned differ on same-sign pair");
            else
                assert_cmp_split_R5: assert (lt_s != lt_u)
                    else $error("signed/unsigned agree on mixed-sign pair");
        end
    end

endmodule

// File: rtl/rv_alu_shift.sv
// Shifter: a logarithmic right shifter with SW stages. Stage s moves the data
// by 2**s when amount bit s is set. A left shift reverses the bits, shifts right
// with a zero fill and reverses again. Assumes W == 2**SW.
module rv_alu_shift #(
    parameter int W  = 32,
    parameter int SW = 5
) (
    input  logic [W-1:0]  a,
    input  logic [SW-1:0] shamt,
    input  logic          left,
    input  logic          arith,
    output logic [W-1:0]  res
);

    logic [W-1:0] a_rev;
    logic [W-1:0] out_rev;
    logic [W-1:0] stg [SW+1];
    logic         fill;

    // Bit reversal of the input and of the final stage.
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign a_rev[i]   = a[W-1-i];
        assign out_rev[i] = stg[SW][W-1-i];
    end

    // The fill bit is the sign bit only for an arithmetic right shift.
    always_comb begin
        fill   = arith & ~left & a[W-1];
        stg[0] = left ? a_rev : a;
    end

    // Shift stages, one for each amount bit.
    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stg[s+1] = shamt[s] ? {{D{fill}}, stg[s][W-1:D]} : stg[s];
    end

    // Undo the reversal for left shifts.
    assign res = left ? out_rev : stg[SW];

    // Fill-value checks on the edge bit next to the vacated positions.
    always_comb begin
        if (!$isunknown({a, shamt, left, arith})) begin
            if (left && shamt != '0)
                assert_sll_zero_fill_R6: assert (res[0] == 1'b0)
                    else $error("left shift did not zero-fill");
            if (!left && !arith && shamt != '0)
                assert_srl_zero_fill_R7: assert (res[W-1] == 1'b0)
                    else $error("logical right shift did not zero-fill");
            if (!left && arith)
                assert_sra_sign_fill_R8: assert (res[W-1] == a[W-1])
                    else $error("arithmetic right shift lost the sign");
        end
    end

endmodule

// File: rtl/rv_int_alu.sv
// Integer ALU top: the adder, comparator and shifter run in parallel with the
// bitwise logic, and the operation code selects one result. Purely
// combinational, so there is no clock or reset. Codes not in rv_alu_pkg give zero.
module rv_int_alu
    import rv_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [OP_W-1:0]  op_sel,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    output logic [WIDTH-1:0] result
);

    localparam int SHW = $clog2(WIDTH);

    logic [WIDTH-1:0] sum_q;
    logic [WIDTH-1:0] shift_q;
    logic             lt_s;
    logic             lt_u;
    logic             is_sub;
    logic             is_left;
    logic             is_arith;
    logic [SHW-1:0]   shamt;

    // Control decode for the shared units; bit 3 marks the alternate form.
    always_comb begin
        is_sub   = (op_sel == OP_SUB);
        is_left  = (op_sel == OP_SLL);
        is_arith = (op_sel == OP_SRA);
        shamt    = src_b[SHW-1:0];
    end

    rv_alu_addsub #(.W(WIDTH)) u_addsub (
        .a   (src_a),
        .b   (src_b),
        .sub (is_sub),
        .sum (sum_q)
    );

    rv_alu_cmp #(.W(WIDTH)) u_cmp (
        .a    (src_a),
        .b    (src_b),
        .lt_s (lt_s),
        .lt_u (lt_u)
    );

    rv_alu_shift #(.W(WIDTH), .SW(SHW)) u_shift (
        .a     (src_a),
        .shamt (shamt),
        .left  (is_left),
        .arith (is_arith),
        .res   (shift_q)
    );

    // Result selection; the default keeps every path assigned.
    always_comb begin
        result = '0;
        case (op_sel)
            OP_ADD, OP_SUB:         result = sum_q;
            OP_SLL, OP_SRL, OP_SRA: result = shift_q;
            OP_SLT:                 result = {{(WIDTH-1){1'b0}}, lt_s};
            OP_SLTU:                result = {{(WIDTH-1){1'b0}}, lt_u};
            OP_XOR:                 result = src_a ^ src_b;
            OP_OR:                  result = src_a | src_b;
            OP_AND:                 result = src_a & src_b;
            default:                result = '0;
        endcase
    end

    // Output-level checks on the selected result.
    always_comb begin
        if (!$isunknown({op_sel, src_a, src_b})) begin
            if (op_sel == OP_SLT || op_sel == OP_SLTU)
                assert_cmp_narrow_R4: assert (result[WIDTH-1:1] == '0)
                    else $error("compare result wider than one bit");
            if (op_sel == OP_XOR)
                assert_xor_inverse_R3: assert ((result ^ src_b) == src_a)
                    else $error("xor does not invert");
            if (op_sel == OP_OR)
                assert_or_cover_R3: assert ((result & src_a) == src_a)
                    else $error("or lost bits of src_a");
            if (op_sel == OP_AND)
                assert_and_subset_R3: assert ((result & ~src_b) == '0)
                    else $error("and set bits outside src_b");
        end
    end

endmodule

// File: tb/tb_rv_int_alu.sv
// Bench: directed corner values and seeded random vectors, checked against a
// reference model computed in this file.
module tb_rv_int_alu;

    logic        clk = 1'b0;
    logic [3:0]  op_sel;
    logic [31:0] src_a, src_b;
    logic [31:0] result;
    int          n_run  = 0;
    int          n_fail = 0;
    bit          done   = 0;

    always #2ns clk = ~clk;  // 250 MHz pacing clock

    rv_int_alu dut (
        .op_sel (op_sel),
        .src_a  (src_a),
        .src_b  (src_b),
        .result (result)
    );

    // Reference model written from the requirements.
    function automatic logic [31:0] ref_alu(input logic [3:0] op,
                                            input logic [31:0] a,
                                            input logic [31:0] b);
        logic [4:0] sh;
        sh = b[4:0];
        case (op)
            4'b0000: return a + b;
            4'b1000: return a - b;
            4'b0001: return a << sh;
            4'b0010: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            4'b0011: return (a < b) ? 32'd1 : 32'd0;
            4'b0100: return a ^ b;
            4'b0101: return a >> sh;
            4'b1101: return 32'($signed(a) >>> sh);
            4'b0110: return a | b;
            4'b0111: return a & b;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'b0000: return "R1";
            4'b1000: return "R2";
            4'b0100, 4'b0110, 4'b0111: return "R3";
            4'b0010: return "R4";
            4'b0011: return "R5";
            4'b0001: return "R6";
            4'b0101: return "R7";
            4'b1101: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        n_run++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h",
                     req, op_sel, src_a, src_b, result, exp);
        end
    endtask

    // Drive on the falling edge, then sample 1 ns later with no clock edge.
    task automatic run(input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input string req);
        @(negedge clk);
        op_sel = op; src_a = a; src_b = b;
        #1ns;
        check(req, ref_alu(op, a, b));
    endtask

    task automatic finish_up();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    localparam logic [3:0] OPS [10] = '{4'b0000, 4'b1000, 4'b0001, 4'b0010,
        4'b0011, 4'b0100, 4'b0101, 4'b1101, 4'b0110, 4'b0111};
    localparam logic [31:0] EDGE [4] = '{32'h0, 32'hFFFF_FFFF,
        32'h8000_0000, 32'h7FFF_FFFF};

    initial begin
        op_sel = 4'b0000; src_a = '0; src_b = '0;
        void'($urandom(32'h1234_5678));
        #1ns;
        check("R1", 32'h0);  // quiet state with all inputs at zero

        // Named corner cases
        run(4'b0000, 32'h7FFF_FFFF, 32'h1, "R1");
        check("R1", 32'h8000_0000);
        run(4'b1000, 32'h0, 32'h1, "R2");
        check("R2", 32'hFFFF_FFFF);
        run(4'b0010, 32'h8000_0000, 32'h7FFF_FFFF, "R4");
        check("R4", 32'd1);
        run(4'b0011, 32'h8000_0000, 32'h7FFF_FFFF, "R5");
        check("R5", 32'd0);
        run(4'b1101, 32'h8000_0000, 32'd31, "R8");
        check("R8", 32'hFFFF_FFFF);
        run(4'b0101, 32'h8000_0000, 32'd31, "R7");
        check("R7", 32'h1);
        run(4'b0001, 32'h1, 32'd31, "R6");
        check("R6", 32'h8000_0000);

        // Upper bits of the shift amount are ignored (R9)
        run(4'b0001, 32'hA5A5_0F0F, 32'h20, "R9");
        check("R9", 32'hA5A5_0F0F);
        run(4'b1101, 32'h8000_00F0, 32'h20, "R9");
        check("R9", 32'h8000_00F0);
        run(4'b0101, 32'hF000_0000, 32'hFFFF_FFE4, "R9");
        check("R9", 32'h0F00_0000);

        // Illegal codes give zero (R10)
        run(4'b1001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10");
        run(4'b1111, 32'h1234_5678, 32'h1, "R10");

        // Input change is visible without any clock edge (R11)
        @(posedge clk); #1ns;
        op_sel = 4'b0100; src_a = 32'hF0F0_F0F0; src_b = 32'h0FF0_0FF0;
        #0.5ns;
        check("R11", 32'hFF00_FF00);

        // Every edge value on both operands under every op code
        for (int o = 0; o < 10; o++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    run(OPS[o], EDGE[i], EDGE[j], req_of(OPS[o]));

        // Random vectors; some pairs are forced to opposite signs
        for (int k = 0; k < 3000; k++) begin
            logic [3:0]  op;
            logic [31:0] a, b;
            op = (k % 8 == 7) ? 4'($urandom) : OPS[$urandom % 10];
            a  = $urandom;
            b  = $urandom;
            if (k % 3 == 0) b[31] = ~a[31];
            run(op, a, b, req_of(op));
        end

        finish_up();
    end

    initial begin
        #(4ns * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

endmodule